// File: doc/BRIEF.md
# Periodic Tick Timer with Match Interrupt

This block is a processor tick timer built from two word-wide registers. The count register advances by one on every cycle in which the fixed-rate tick enable is high. The control register holds a period value, an interrupt enable, a sticky interrupt pending flag and a two-bit mode. A match happens when an increment brings the low-order period field of the count to the programmed period. That match raises the pending flag if interrupts are enabled. Depending on the mode, the count then clears, halts or keeps running.

Software reaches both registers through one synchronous port. A select line picks the register. A write takes effect at the clock edge, and read data appears one cycle later from an output register. The interrupt output is a level that stays high while the pending flag and the enable are both set.

Top module: `tick_timer`

## Requirements
- R1: After synchronous reset both registers read as zero and `irq` is low.
- R2: While not halted, the count rises by exactly one on each cycle with `tick_en` high. With `tick_en` low the count holds its value.
- R3: A count write (`reg_sel`=1, `wr_en`=1) loads `wr_data` and overrides a tick in the same cycle.
- R4: A match is judged only on the period field (bits W-5:0, bits 27:0 at default width). If the period is at or below the masked count, the next match comes only after that field wraps through zero. A period of zero therefore needs a full wrap.
- R5: A match sets the pending flag (bit W-4, bit 28 at default) only if the enable (bit W-3, bit 29) is set. `irq` is high exactly when both bits are set.
- R6: In restart mode (bits W-1:W-2 = 01) a match loads zero into the whole count.
- R7: In one-shot mode (10) a match leaves the count equal to the period and halts it. A later control write with a nonzero mode resumes counting.
- R8: In continuous mode (11) a match does not disturb the count, which keeps rising past the period.
- R9: In disabled mode (00) the count still advances, but no match ever occurs.
- R10: The pending flag only changes in three ways. A control write loads it from bit W-4 of `wr_data`. A match in the same cycle as that write keeps it set. Otherwise it never clears by itself.
- R11: `rd_data` shows, one cycle after the edge, the register picked by `reg_sel` (0 control, 1 count) as it stood before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Fixed-rate count enable |
| reg_sel | input | 1 | Register select: 0 control, 1 count |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data |
| irq | output | 1 | Level interrupt |

## Verification
The tick-driven match and a software write can land on the same edge, and two pairings matter. In the first, a control write that clears the pending flag meets a match, and the flag must stay set. In the second, a count write meets a tick, and the written value must win. The bench drives `tick_en` and the write strobe in one cycle with the count one step below the period. It then reads both registers back and requires the pending flag set and the count cleared. The same write repeated without a tick must clear the flag.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  typedef enum logic [1:0] {
    TT_OFF     = 2'b00,
    TT_RESTART = 2'b01,
    TT_ONESHOT = 2'b10,
    TT_FREE    = 2'b11
  } tt_mode_e;
endpackage

// File: rtl/tt_count_reg.sv
module tt_count_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  input  logic         clr,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_inc
);
  assign cnt_inc = cnt_q + W'(1);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (step) cnt_q <= clr ? '0 : cnt_inc;
  end
endmodule

// File: rtl/tt_match.sv
module tt_match
  import tick_timer_pkg::*;
#(
  parameter int PW = 28
) (
  input  logic          run,
  input  tt_mode_e      mode,
  input  logic [PW-1:0] next_lo,
  input  logic [PW-1:0] period,
  output logic          hit
);
  always_comb begin
    hit = 1'b0;
    if (run && mode != TT_OFF && next_lo == period) hit = 1'b1;
  end
endmodule

// File: rtl/tt_ctrl_reg.sv
module tt_ctrl_reg
  import tick_timer_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         hit,
  output tt_mode_e     mode,
  output logic         ie,
  output logic         pend,
  output logic [W-5:0] period,
  output logic         halted,
  output logic [W-1:0] word
);
  localparam int PW    = W - 4;
  localparam int IE_B  = W - 3;
  localparam int IP_B  = W - 4;

  logic set_pend;
  tt_mode_e wmode;

  assign set_pend = hit & ie;
  assign wmode    = tt_mode_e'(wdata[W-1:W-2]);
  assign word     = {mode, ie, pend, period};

  always_ff @(posedge clk) begin
    if (rst) begin
      mode   <= TT_OFF;
      ie     <= 1'b0;
      period <= '0;
    end else if (wr) begin
      mode   <= wmode;
      ie     <= wdata[IE_B];
      period <= wdata[PW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     pend <= 1'b0;
    else if (wr) pend <= wdata[IP_B] | set_pend;
    else         pend <= pend | set_pend;
  end

  always_ff @(posedge clk) begin
    if (rst)                         halted <= 1'b0;
    else if (wr && wmode != TT_OFF)  halted <= 1'b0;
    else if (hit && mode == TT_ONESHOT) halted <= 1'b1;
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              reg_sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  localparam int PW = DATA_W - 4;

  logic              wr_ctrl, wr_cnt, run, hit, clr;
  logic [DATA_W-1:0] cnt_q, cnt_inc, ctrl_word;
  logic [PW-1:0]     period;
  tt_mode_e          mode;
  logic              ie, pend, halted;

  assign wr_ctrl = wr_en & ~reg_sel;
  assign wr_cnt  = wr_en &  reg_sel;
  assign run     = tick_en & ~halted & ~wr_cnt;
  assign clr     = hit & (mode == TT_RESTART);

  tt_count_reg #(.W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .load(wr_cnt), .load_val(wr_data),
    .step(run), .clr(clr), .cnt_q(cnt_q), .cnt_inc(cnt_inc)
  );

  tt_match #(.PW(PW)) u_match (
    .run(run), .mode(mode), .next_lo(cnt_inc[PW-1:0]),
    .period(period), .hit(hit)
  );

  tt_ctrl_reg #(.W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr(wr_ctrl), .wdata(wr_data), .hit(hit),
    .mode(mode), .ie(ie), .pend(pend), .period(period),
    .halted(halted), .word(ctrl_word)
  );

  assign irq = pend & ie;

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= reg_sel ? cnt_q : ctrl_word;
  end
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_en,
  input logic              reg_sel,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] cnt_q,
  input logic              pend,
  input logic              halted,
  input logic              irq
);
  // R3
  cnt_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_sel) |=> cnt_q == $past(wr_data));
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !(wr_en && reg_sel)) |=> $stable(cnt_q));
  // R7
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (halted && !(wr_en && reg_sel)) |=> $stable(cnt_q));
  // R10
  pend_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (pend && !(wr_en && !reg_sel && !wr_data[DATA_W-4])) |=> pend);
  // R5
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(tick_en || wr_en));
endmodule

bind tick_timer tick_timer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .tick_en(tick_en), .reg_sel(reg_sel),
  .wr_en(wr_en), .wr_data(wr_data), .cnt_q(cnt_q), .pend(pend),
  .halted(halted), .irq(irq)
);

// File: tb/tick_timer_tb.sv
module tick_timer_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tick_en = 1'b0;
  logic         reg_sel = 1'b0;
  logic         wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic         irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tick_timer #(.DATA_W(W)) u_dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .reg_sel(reg_sel),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  function automatic logic [W-1:0] ctl(int m, int e, int p, int per);
    return {m[1:0], e[0], p[0], per[3:0]};
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic sel, logic [W-1:0] d);
    reg_sel = sel; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic sel, output int v);
    reg_sel = sel; wr_en = 1'b0; tick_en = 1'b0;
    @(negedge clk);
    v = int'(rd_data);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick_en = 1'b1;
      @(negedge clk);
    end
    tick_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq", int'(irq), 0);
    rd(1'b1, v); chk("R1 count", v, 0);
    rd(1'b0, v); chk("R11 R1 ctrl", v, 0);

    // R6 restart sweep, R5 interrupt
    for (int p = 1; p < 16; p++) begin
      wr(1'b1, '0);
      wr(1'b0, ctl(1, 1, 0, p));
      ticks(p - 1);
      rd(1'b1, v); chk("R6 before match", v, p - 1);
      chk("R5 no irq before match", int'(irq), 0);
      ticks(1);
      rd(1'b1, v); chk("R6 cleared", v, 0);
      chk("R5 irq on match", int'(irq), 1);
      wr(1'b0, ctl(1, 1, 0, p));
      chk("R10 clear by write", int'(irq), 0);
      ticks(2 * p + 3);
      rd(1'b1, v); chk("R6 modulo", v, (2 * p + 3) % p);
      rd(1'b0, v); chk("R11 ctrl word", v, int'(ctl(1, 1, 1, p)));
    end

    // R7 one-shot sweep
    for (int p = 1; p < 16; p++) begin
      wr(1'b0, ctl(0, 0, 0, 0));
      wr(1'b1, '0);
      wr(1'b0, ctl(2, 1, 0, p));
      ticks(p);
      rd(1'b1, v); chk("R7 stop at period", v, p);
      chk("R5 one-shot irq", int'(irq), 1);
      ticks(5);
      rd(1'b1, v); chk("R7 halted", v, p);
      wr(1'b0, ctl(3, 0, 0, p));
      ticks(1);
      rd(1'b1, v); chk("R7 resume", v, p + 1);
    end

    // R8 continuous sweep
    for (int p = 1; p < 16; p++) begin
      wr(1'b0, ctl(0, 0, 0, 0));
      wr(1'b1, '0);
      wr(1'b0, ctl(3, 1, 0, p));
      ticks(p - 1);
      chk("R8 no irq yet", int'(irq), 0);
      ticks(1);
      chk("R8 irq at period", int'(irq), 1);
      ticks(20 - p);
      rd(1'b1, v); chk("R8 runs past match", v, 20);
    end

    // R4 wrap when period below masked count
    wr(1'b0, ctl(0, 0, 0, 0));
    wr(1'b1, 8'd9);
    wr(1'b0, ctl(1, 1, 0, 5));
    ticks(11);
    rd(1'b1, v); chk("R4 wrap before match", v, 20);
    chk("R4 no early irq", int'(irq), 0);
    ticks(1);
    rd(1'b1, v); chk("R4 wrap match", v, 0);
    chk("R4 irq", int'(irq), 1);
    // R4 period zero
    wr(1'b1, '0);
    wr(1'b0, ctl(1, 1, 0, 0));
    ticks(15);
    rd(1'b1, v); chk("R4 period0 pre", v, 15);
    chk("R4 period0 no irq", int'(irq), 0);
    ticks(1);
    rd(1'b1, v); chk("R4 period0 match", v, 0);
    chk("R4 period0 irq", int'(irq), 1);

    // R9 disabled mode counts without matching
    wr(1'b0, ctl(0, 1, 0, 3));
    wr(1'b1, '0);
    ticks(10);
    rd(1'b1, v); chk("R9 counts", v, 10);
    rd(1'b0, v); chk("R9 no pending", v, int'(ctl(0, 1, 0, 3)));
    chk("R9 irq low", int'(irq), 0);

    // R5 enable clear: no pending
    wr(1'b0, ctl(1, 0, 0, 4));
    wr(1'b1, '0);
    ticks(4);
    rd(1'b1, v); chk("R6 restart with ie off", v, 0);
    rd(1'b0, v); chk("R5 no pending with ie off", v, int'(ctl(1, 0, 0, 4)));

    // R2 hold with tick low
    wr(1'b0, ctl(3, 0, 0, 15));
    wr(1'b1, 8'd7);
    repeat (6) @(negedge clk);
    rd(1'b1, v); chk("R2 hold", v, 7);
    ticks(3);
    rd(1'b1, v); chk("R2 step", v, 10);

    // R3 write beats tick
    tick_en = 1'b1;
    wr(1'b1, 8'h33);
    tick_en = 1'b0;
    rd(1'b1, v); chk("R3 write priority", v, 8'h33);

    // R10 collision: clearing write meets a match
    wr(1'b0, ctl(1, 1, 0, 2));
    wr(1'b1, 8'd1);
    tick_en = 1'b1;
    wr(1'b0, ctl(1, 1, 0, 2));
    tick_en = 1'b0;
    chk("R10 match wins over clear", int'(irq), 1);
    rd(1'b1, v); chk("R10 collision count", v, 0);
    wr(1'b0, ctl(1, 1, 0, 2));
    chk("R10 clear alone", int'(irq), 0);
    wr(1'b0, ctl(0, 1, 1, 2));
    chk("R10 software set", int'(irq), 1);
    rd(1'b0, v); chk("R11 set word", v, int'(ctl(0, 1, 1, 2)));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule